// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation entries from memory. It reads one word from a per-context root table, then follows pointer entries down through at most three table levels. Any level below the root can end the walk with a leaf, so pages of 16 MB, 256 KB or 4 KB all come out of the same machine. When the walk hits a bad entry, the block reports a fault code that gives both the level and the kind of error. A separate block checks permissions and keeps the fault registers.

A requester presents an address, an access kind and a privilege flag while `busy` is low. The walker then issues reads on a simple word memory port, one at a time, and waits a variable number of cycles for each reply. It raises `done` for one cycle with the result. When a leaf's usage bits need updating, it writes the entry back to the address it was read from before it reports. When translation is off, the address passes straight through, except that instruction fetches in boot mode are steered into a fixed boot-ROM window.

Top module: `ptw_walker`

## Requirements
- R1: After reset, and whenever no walk is in progress, `busy` and `done` are low and neither memory request is raised.
- R2: The first read of a translated walk is at `{cfg_ctx_ptr, 4'b0} + cfg_ctx_num*4`.
- R3: A pointer entry (bits [1:0] = 1) gives the next table base as `{entry[31:2], 6'b0}`. The next read is at base + 4*index, where the index is vaddr[31:24] for the first level, vaddr[23:18] for the second and vaddr[17:12] for the third.
- R4: A leaf (bits [1:0] = 2) at level 1, 2 or 3 gives `rsp_size` 2, 1 or 0 (16 MB, 256 KB, 4 KB). It gives `rsp_paddr = {entry[31:8], 12'b0}` plus vaddr[23:0], vaddr[17:0] or vaddr[11:0] respectively.
- R5: An invalid entry (bits [1:0] = 0) ends the walk with `rsp_fault = level*256 + 4`. The root table is level 0.
- R6: A wrong-kind entry ends the walk with `rsp_fault = level*256 + 16`. This covers a reserved entry (bits [1:0] = 3), a leaf in the root table and a pointer at level 3.
- R7: With `cfg_enable` low, no memory is touched. `done` follows in the cycle after acceptance with `rsp_paddr` equal to the zero-extended vaddr, `rsp_prot` = 3'b111 ({exec,write,read}) and `rsp_size` = 0.
- R8: With `cfg_enable` low and `cfg_boot` high, a fetch (`req_kind` = 2) returns `PROM_BASE | vaddr[18:0]` with `rsp_prot` = 3'b101. Loads (0) and stores (1) pass through as in R7.
- R9: On a leaf with the referenced bit (bit 5) clear, or a store with the modified bit (bit 6) clear, the walker writes the entry with bit 5 set back to the address it came from. On a store, bit 6 is set as well. Otherwise nothing is written. `rsp_pte` carries the updated entry.
- R10: At most one read is outstanding. A read request is a one-cycle pulse, and each level is read exactly once.
- R11: `busy` rises the cycle after a request is accepted and stays high through the `done` cycle. `done` is a one-cycle pulse. Requests raised while `busy` is high are ignored.
- R12: A faulting result has `rsp_paddr` = 0 and `rsp_pte` = the offending entry. Walked results have `rsp_prot` = 0. `rsp_user` echoes `req_user` for every result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when busy is low |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 instruction fetch |
| req_user | input | 1 | Privilege flag of the requester, returned with the result |
| busy | output | 1 | Walk in progress; new requests ignored |
| cfg_enable | input | 1 | Translation enabled |
| cfg_boot | input | 1 | Boot mode: fetches go to the ROM window when translation is off |
| cfg_ctx_ptr | input | PA_W-4 (32) | Root table pointer, in 16-byte units |
| cfg_ctx_num | input | CTX_W (8) | Current context number |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_wr_req | output | 1 | One-cycle write request |
| mem_addr | output | PA_W (36) | Byte address of the word |
| mem_wdata | output | 32 | Write data (updated leaf) |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read reply strobe |
| done | output | 1 | One-cycle result strobe |
| rsp_paddr | output | PA_W (36) | Physical address |
| rsp_size | output | 2 | Page size code: 0 4 KB, 1 256 KB, 2 16 MB |
| rsp_pte | output | 32 | Final entry read (updated leaf, or offending entry) |
| rsp_fault | output | 10 | Fault code, level in [9:8], error type in [7:2]; 0 on success |
| rsp_prot | output | 3 | {exec,write,read} for untranslated results |
| rsp_user | output | 1 | Echo of req_user |

## Verification
The bench builds table trees in a sparse memory and uses memory latencies from one to four cycles. A behavioural walker predicts every read address, the result and any write-back. It aims at walks that end at each level, including the wrong-kind cases: a leaf at the root, a pointer at level 3 and reserved entries. A design that gets the level wrong in the fault code, or does not stop at the last level, would report a wrong code or read past the table. The bench repeats loads and stores on the same leaf, so a missed or spurious write-back shows up as a changed write count or wrong memory contents. It also raises a request in the middle of a walk, which a design that restarts on it would answer with the wrong address and extra reads.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH_CTX,
      ST_FETCH_L1,
      ST_FETCH_L2,
      ST_FETCH_L3,
      ST_WRITEBACK,
      ST_DONE
   } ptw_state_e;

   typedef enum logic [1:0] {
      ET_INVALID = 2'd0,
      ET_TABLE   = 2'd1,
      ET_LEAF    = 2'd2,
      ET_RSVD    = 2'd3
   } ptw_etype_e;

   localparam logic [1:0] ACC_LOAD  = 2'd0;
   localparam logic [1:0] ACC_STORE = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;

   localparam logic [5:0] ERR_NONE    = 6'd0;
   localparam logic [5:0] ERR_INVALID = 6'd1;
   localparam logic [5:0] ERR_BADKIND = 6'd4;

   localparam int REF_BIT = 5;
   localparam int MOD_BIT = 6;

   localparam logic [2:0] PROT_NONE = 3'b000;
   localparam logic [2:0] PROT_RX   = 3'b101;
   localparam logic [2:0] PROT_RWX  = 3'b111;

   localparam logic [1:0] SZ_4K = 2'd0;

   function automatic logic [1:0] state_level(ptw_state_e s);
      case (s)
         ST_FETCH_L1: return 2'd1;
         ST_FETCH_L2: return 2'd2;
         ST_FETCH_L3: return 2'd3;
         default:     return 2'd0;
      endcase
   endfunction

   function automatic ptw_state_e state_descend(ptw_state_e s);
      case (s)
         ST_FETCH_CTX: return ST_FETCH_L1;
         ST_FETCH_L1:  return ST_FETCH_L2;
         default:      return ST_FETCH_L3;
      endcase
   endfunction

endpackage

// File: rtl/ptw_fetch_addr.sv
module ptw_fetch_addr
   import ptw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int L1_BITS   = 8,
   parameter int L2_BITS   = 6,
   parameter int L3_BITS   = 6,
   parameter int CTX_W     = 8,
   parameter int PA_W      = 36,
   localparam int HI_W     = VA_W - PAGE_BITS
) (
   input  logic [1:0]      lvl,
   input  logic [HI_W-1:0] va_hi,
   input  logic [PA_W-5:0] ctx_ptr,
   input  logic [CTX_W-1:0] ctx_num,
   input  logic [PA_W-1:0] tbl_base,
   output logic [PA_W-1:0] addr
);

   logic [PA_W-1:0] idx_off [4];
   logic [PA_W-1:0] root_addr;

   assign idx_off[0] = '0;

   for (genvar g = 1; g <= 3; g++) begin : g_idx
      localparam int LO = (g == 1) ? (L2_BITS + L3_BITS) : ((g == 2) ? L3_BITS : 0);
      localparam int W  = (g == 1) ? L1_BITS : ((g == 2) ? L2_BITS : L3_BITS);
      assign idx_off[g] = PA_W'({va_hi[LO +: W], 2'b00});
   end

   assign root_addr = {ctx_ptr, 4'b0000} + PA_W'({ctx_num, 2'b00});
   assign addr      = (lvl == 2'd0) ? root_addr : (tbl_base + idx_off[lvl]);

endmodule

// File: rtl/ptw_entry_classify.sv
module ptw_entry_classify
   import ptw_pkg::*;
(
   input  logic [1:0] lvl,
   input  logic [1:0] etype,
   output logic       go_next,
   output logic       is_leaf,
   output logic       is_fault,
   output logic [9:0] code
);

   logic [5:0] err;

   always_comb begin
      go_next = 1'b0;
      is_leaf = 1'b0;
      err     = ERR_NONE;
      case (ptw_etype_e'(etype))
         ET_INVALID: err = ERR_INVALID;
         ET_TABLE: begin
            if (lvl == 2'd3) err = ERR_BADKIND;
            else             go_next = 1'b1;
         end
         ET_LEAF: begin
            if (lvl == 2'd0) err = ERR_BADKIND;
            else             is_leaf = 1'b1;
         end
         default: err = ERR_BADKIND;
      endcase
   end

   assign is_fault = (err != ERR_NONE);
   assign code     = {lvl, err, 2'b00};

endmodule

// File: rtl/ptw_leaf_map.sv
module ptw_leaf_map
   import ptw_pkg::*;
#(
   parameter int PAGE_BITS = 12,
   parameter int L2_BITS   = 6,
   parameter int L3_BITS   = 6,
   parameter int ENTRY_W   = 32,
   parameter int PA_W      = 36,
   localparam int OFF_W    = L2_BITS + L3_BITS + PAGE_BITS
) (
   input  logic [1:0]         lvl,
   input  logic [OFF_W-1:0]   va_off,
   input  logic [ENTRY_W-1:0] entry,
   input  logic               is_store,
   output logic [PA_W-1:0]    paddr,
   output logic [1:0]         size,
   output logic [ENTRY_W-1:0] new_entry,
   output logic               need_wb
);

   logic [OFF_W-1:0] off_sel [4];

   assign off_sel[0] = '0;

   for (genvar g = 1; g <= 3; g++) begin : g_off
      localparam int KEEP = PAGE_BITS + ((g <= 2) ? L3_BITS : 0) + ((g == 1) ? L2_BITS : 0);
      if (KEEP == OFF_W) begin : g_full
         assign off_sel[g] = va_off;
      end else begin : g_part
         assign off_sel[g] = {{(OFF_W - KEEP){1'b0}}, va_off[KEEP-1:0]};
      end
   end

   assign paddr = {entry[ENTRY_W-1:8], {PAGE_BITS{1'b0}}} + PA_W'(off_sel[lvl]);
   assign size  = 2'd3 - lvl;

   assign need_wb = !entry[REF_BIT] || (is_store && !entry[MOD_BIT]);

   always_comb begin
      new_entry          = entry;
      new_entry[REF_BIT] = 1'b1;
      if (is_store) new_entry[MOD_BIT] = 1'b1;
   end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int L1_BITS   = 8,
   parameter int L2_BITS   = 6,
   parameter int L3_BITS   = 6,
   parameter int CTX_W     = 8,
   parameter int ENTRY_W   = 32,
   parameter int PROM_BITS = 19,
   localparam int PA_W     = ENTRY_W - 8 + PAGE_BITS,
   parameter logic [PA_W-1:0] PROM_BASE = 36'hF_F000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [1:0]         req_kind,
   input  logic               req_user,
   output logic               busy,
   input  logic               cfg_enable,
   input  logic               cfg_boot,
   input  logic [PA_W-5:0]    cfg_ctx_ptr,
   input  logic [CTX_W-1:0]   cfg_ctx_num,
   output logic               mem_rd_req,
   output logic               mem_wr_req,
   output logic [PA_W-1:0]    mem_addr,
   output logic [ENTRY_W-1:0] mem_wdata,
   input  logic [ENTRY_W-1:0] mem_rdata,
   input  logic               mem_rvalid,
   output logic               done,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [1:0]         rsp_size,
   output logic [ENTRY_W-1:0] rsp_pte,
   output logic [9:0]         rsp_fault,
   output logic [2:0]         rsp_prot,
   output logic               rsp_user
);

   localparam int HI_W  = VA_W - PAGE_BITS;
   localparam int OFF_W = L2_BITS + L3_BITS + PAGE_BITS;

   if (L1_BITS + L2_BITS + L3_BITS + PAGE_BITS != VA_W) begin : g_bad_split
      $error("index fields and page offset must cover the virtual address");
   end
   if (PA_W < VA_W || PROM_BITS > VA_W) begin : g_bad_width
      $error("physical width too small for pass-through");
   end
   if (ENTRY_W + 4 != PA_W) begin : g_bad_entry
      $error("table pointer field does not fill the physical address");
   end

   ptw_state_e         state;
   logic               rd_pend;
   logic [VA_W-1:0]    va_q;
   logic [1:0]         kind_q;
   logic [PA_W-1:0]    cur_base;
   logic [PA_W-1:0]    last_addr;
   logic [ENTRY_W-1:0] wb_q;

   logic [1:0]         lvl;
   logic               fetching;
   logic [PA_W-1:0]    fetch_addr;
   logic               c_next, c_leaf, c_fault;
   logic [9:0]         c_code;
   logic [PA_W-1:0]    l_paddr;
   logic [1:0]         l_size;
   logic [ENTRY_W-1:0] l_entry;
   logic               l_wb;
   logic [PA_W-1:0]    next_base;

   assign lvl      = state_level(state);
   assign fetching = (state == ST_FETCH_CTX) || (state == ST_FETCH_L1) ||
                     (state == ST_FETCH_L2)  || (state == ST_FETCH_L3);

   ptw_fetch_addr #(
      .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
      .L3_BITS(L3_BITS), .CTX_W(CTX_W), .PA_W(PA_W)
   ) u_addr (
      .lvl      (lvl),
      .va_hi    (va_q[VA_W-1:PAGE_BITS]),
      .ctx_ptr  (cfg_ctx_ptr),
      .ctx_num  (cfg_ctx_num),
      .tbl_base (cur_base),
      .addr     (fetch_addr)
   );

   ptw_entry_classify u_cls (
      .lvl      (lvl),
      .etype    (mem_rdata[1:0]),
      .go_next  (c_next),
      .is_leaf  (c_leaf),
      .is_fault (c_fault),
      .code     (c_code)
   );

   ptw_leaf_map #(
      .PAGE_BITS(PAGE_BITS), .L2_BITS(L2_BITS), .L3_BITS(L3_BITS),
      .ENTRY_W(ENTRY_W), .PA_W(PA_W)
   ) u_leaf (
      .lvl       (lvl),
      .va_off    (va_q[OFF_W-1:0]),
      .entry     (mem_rdata),
      .is_store  (kind_q == ACC_STORE),
      .paddr     (l_paddr),
      .size      (l_size),
      .new_entry (l_entry),
      .need_wb   (l_wb)
   );

   assign next_base  = {mem_rdata[ENTRY_W-1:2], 6'b000000};
   assign mem_rd_req = fetching && !rd_pend;
   assign mem_wr_req = (state == ST_WRITEBACK);
   assign mem_addr   = (state == ST_WRITEBACK) ? last_addr : fetch_addr;
   assign mem_wdata  = wb_q;
   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rd_pend   <= 1'b0;
         va_q      <= '0;
         kind_q    <= ACC_LOAD;
         cur_base  <= '0;
         last_addr <= '0;
         wb_q      <= '0;
         rsp_paddr <= '0;
         rsp_size  <= SZ_4K;
         rsp_pte   <= '0;
         rsp_fault <= '0;
         rsp_prot  <= PROT_NONE;
         rsp_user  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q      <= req_vaddr;
                  kind_q    <= req_kind;
                  rsp_user  <= req_user;
                  rsp_pte   <= '0;
                  rsp_fault <= '0;
                  rsp_size  <= SZ_4K;
                  rd_pend   <= 1'b0;
                  if (!cfg_enable) begin
                     state <= ST_DONE;
                     if (cfg_boot && req_kind == ACC_FETCH) begin
                        rsp_paddr <= PROM_BASE | PA_W'(req_vaddr[PROM_BITS-1:0]);
                        rsp_prot  <= PROT_RX;
                     end else begin
                        rsp_paddr <= PA_W'(req_vaddr);
                        rsp_prot  <= PROT_RWX;
                     end
                  end else begin
                     state     <= ST_FETCH_CTX;
                     rsp_paddr <= '0;
                     rsp_prot  <= PROT_NONE;
                  end
               end
            end
            ST_FETCH_CTX, ST_FETCH_L1, ST_FETCH_L2, ST_FETCH_L3: begin
               if (mem_rd_req) begin
                  rd_pend   <= 1'b1;
                  last_addr <= fetch_addr;
               end else if (mem_rvalid) begin
                  rd_pend <= 1'b0;
                  if (c_next) begin
                     cur_base <= next_base;
                     state    <= state_descend(state);
                  end else if (c_leaf) begin
                     rsp_paddr <= l_paddr;
                     rsp_size  <= l_size;
                     rsp_pte   <= l_entry;
                     wb_q      <= l_entry;
                     state     <= l_wb ? ST_WRITEBACK : ST_DONE;
                  end else if (c_fault) begin
                     rsp_fault <= c_code;
                     rsp_pte   <= mem_rdata;
                     state     <= ST_DONE;
                  end
               end
            end
            ST_WRITEBACK: state <= ST_DONE;
            ST_DONE:      state <= ST_IDLE;
            default:      state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int PA_W = 36
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            busy,
   input logic            done,
   input logic            mem_rd_req,
   input logic            mem_wr_req,
   input logic            wb_ref,
   input logic [7:0]      flt_lo,
   input logic [PA_W-1:0] rsp_paddr
);

   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd_req && !mem_wr_req));

   a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);

   a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));

   a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy);

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   a_r9_wb_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> wb_ref);

   a_r9_wb_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |=> done);

   a_r6_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flt_lo != 8'd0) |-> ((flt_lo == 8'd4) || (flt_lo == 8'd16)));

   a_r12_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flt_lo != 8'd0) |-> (rsp_paddr == '0));

endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .busy       (busy),
   .done       (done),
   .mem_rd_req (mem_rd_req),
   .mem_wr_req (mem_wr_req),
   .wb_ref     (mem_wdata[5]),
   .flt_lo     (rsp_fault[7:0]),
   .rsp_paddr  (rsp_paddr)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_user = 1'b0;
   logic        busy;
   logic        cfg_enable = 1'b1;
   logic        cfg_boot = 1'b0;
   logic [31:0] cfg_ctx_ptr = 32'h0000_1000;
   logic [7:0]  cfg_ctx_num = 8'd3;
   logic        mem_rd_req, mem_wr_req;
   logic [35:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_rvalid = 1'b0;
   logic        done;
   logic [35:0] rsp_paddr;
   logic [1:0]  rsp_size;
   logic [31:0] rsp_pte;
   logic [9:0]  rsp_fault;
   logic [2:0]  rsp_prot;
   logic        rsp_user;

   localparam logic [35:0] PROM = 36'hF_F000_0000;

   always #4 clk = ~clk;

   ptw_walker u_dut (.*);

   int nchk = 0;
   int nerr = 0;
   int nreads = 0;
   int nwrites = 0;
   int mem_lat = 2;
   int rd_cnt = 0;
   logic [35:0] rd_a = '0;
   logic [31:0] mem [logic [35:0]];
   logic [35:0] got_addrs [$];
   logic [35:0] exp_addrs [$];

   function automatic logic [31:0] rd_mem(logic [35:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   function automatic logic [31:0] ptr_to(logic [35:0] b);
      return 32'(b >> 4) | 32'h1;
   endfunction

   function automatic logic [31:0] leaf(logic [23:0] ppn, logic [7:0] fl);
      return {ppn, fl[7:2], 2'b10};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // memory model: sparse words, fixed latency, one reply per request
   always @(negedge clk) begin
      mem_rvalid = 1'b0;
      if (rd_cnt > 0) begin
         rd_cnt--;
         if (rd_cnt == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = rd_mem(rd_a);
         end
      end
      if (rst_n && mem_rd_req) begin
         if (rd_cnt != 0) chk(1'b0, "R10", 64'(rd_cnt), 64'd0);
         rd_a   = mem_addr;
         rd_cnt = mem_lat;
         got_addrs.push_back(mem_addr);
         nreads++;
      end
      if (rst_n && mem_wr_req) begin
         mem[mem_addr] = mem_wdata;
         nwrites++;
      end
   end

   // behavioural reference walk
   task automatic ref_walk(input logic [31:0] va, input logic [1:0] kind,
                           output logic [35:0] pa, output logic [1:0] sz,
                           output logic [31:0] pte, output logic [9:0] flt,
                           output logic [2:0] prot, output bit wb,
                           output logic [35:0] wa, output logic [31:0] wd);
      logic [35:0] a;
      logic [31:0] e;
      int lv;
      exp_addrs.delete();
      pa = '0; sz = 2'd0; pte = '0; flt = '0; prot = 3'b000; wb = 0; wa = '0; wd = '0;
      if (!cfg_enable) begin
         if (cfg_boot && kind == 2'd2) begin
            pa = PROM | 36'(va[18:0]); prot = 3'b101;
         end else begin
            pa = 36'(va); prot = 3'b111;
         end
         return;
      end
      a  = {cfg_ctx_ptr, 4'b0} + 36'(cfg_ctx_num) * 4;
      lv = 0;
      forever begin
         exp_addrs.push_back(a);
         e = rd_mem(a);
         if (e[1:0] == 2'd0) begin
            flt = 10'(lv * 256 + 4); pte = e; return;
         end
         if (e[1:0] == 2'd3 || (e[1:0] == 2'd1 && lv == 3) || (e[1:0] == 2'd2 && lv == 0)) begin
            flt = 10'(lv * 256 + 16); pte = e; return;
         end
         if (e[1:0] == 2'd2) begin
            logic [35:0] off;
            off = (lv == 1) ? 36'(va[23:0]) : (lv == 2) ? 36'(va[17:0]) : 36'(va[11:0]);
            pa  = (36'(e[31:8]) << 12) + off;
            sz  = 2'(3 - lv);
            wd  = e | 32'h20 | ((kind == 2'd1) ? 32'h40 : 32'h0);
            pte = wd;
            wb  = !e[5] || (kind == 2'd1 && !e[6]);
            wa  = a;
            return;
         end
         lv++;
         a = (36'(e) & ~36'h3) << 4;
         if (lv == 1)      a = a + 36'(va[31:24]) * 4;
         else if (lv == 2) a = a + 36'(va[23:18]) * 4;
         else              a = a + 36'(va[17:12]) * 4;
      end
   endtask

   task automatic do_txn(input logic [31:0] va, input logic [1:0] kind, input string tag, input bit poke);
      logic [35:0] pa, wa;
      logic [1:0]  sz;
      logic [31:0] pte, wd;
      logic [9:0]  flt;
      logic [2:0]  prot;
      bit          wb;
      bit          busy_ok;
      int          r0, w0, cyc;
      logic        usr;
      ref_walk(va, kind, pa, sz, pte, flt, prot, wb, wa, wd);
      usr = ~usr_toggle;
      usr_toggle = usr;
      got_addrs.delete();
      r0 = nreads; w0 = nwrites;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = usr;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R11", 64'(busy), 64'd1);
      busy_ok = 1; cyc = 0;
      while (!done && cyc < 300) begin
         if (!busy) busy_ok = 0;
         @(negedge clk);
         cyc++;
         if (poke && cyc == 1 && !done) begin
            req_valid = 1'b1; req_vaddr = va ^ 32'h0500_0000; req_kind = 2'd1;
         end else begin
            req_valid = 1'b0;
         end
      end
      req_valid = 1'b0;
      chk(busy_ok && done, "R11", 64'(done), 64'd1);
      chk(rsp_fault == flt, tag, 64'(rsp_fault), 64'(flt));
      chk(rsp_paddr == pa, (flt != 0) ? "R12" : tag, 64'(rsp_paddr), 64'(pa));
      chk(rsp_pte == pte, (flt != 0) ? "R12" : tag, 64'(rsp_pte), 64'(pte));
      chk(rsp_size == sz, tag, 64'(rsp_size), 64'(sz));
      chk(rsp_prot == prot, tag, 64'(rsp_prot), 64'(prot));
      chk(rsp_user == usr, "R12", 64'(rsp_user), 64'(usr));
      chk(got_addrs.size() == exp_addrs.size(), "R10", 64'(got_addrs.size()), 64'(exp_addrs.size()));
      foreach (exp_addrs[i]) begin
         if (i < got_addrs.size())
            chk(got_addrs[i] == exp_addrs[i], (i == 0) ? "R2" : "R3", 64'(got_addrs[i]), 64'(exp_addrs[i]));
      end
      chk(nwrites - w0 == int'(wb), "R9", 64'(nwrites - w0), 64'(wb));
      if (wb) chk(rd_mem(wa) == wd, "R9", 64'(rd_mem(wa)), 64'(wd));
      @(negedge clk);
      chk(!busy && !done, "R11", 64'({busy, done}), 64'd0);
      if (poke) begin
         repeat (4) @(negedge clk);
         chk(nreads == r0 + exp_addrs.size(), "R11", 64'(nreads - r0), 64'(exp_addrs.size()));
      end
   endtask

   logic usr_toggle = 1'b0;

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // root table at 0x10000
      mem[36'h1000C] = ptr_to(36'h20000);          // ctx 3
      mem[36'h10010] = 32'h0;                      // ctx 4 invalid
      mem[36'h10014] = leaf(24'h000123, 8'h60);    // ctx 5 leaf at root
      // first level at 0x20000
      mem[36'h20004] = leaf(24'h000500, 8'h1C);    // 16 MB, R and M clear
      mem[36'h20008] = ptr_to(36'h30000);
      mem[36'h2000C] = 32'h0;
      mem[36'h20010] = 32'h0000_0A13;              // reserved
      // second level at 0x30000
      mem[36'h30014] = leaf(24'h000A40, 8'h60);    // 256 KB, R and M set
      mem[36'h30018] = ptr_to(36'h40000);
      mem[36'h3001C] = 32'h0;
      mem[36'h30020] = 32'h0000_0AB3;
      // third level at 0x40000
      mem[36'h40024] = leaf(24'h0077C1, 8'h20);    // 4 KB, R set, M clear
      mem[36'h40028] = ptr_to(36'h50000);          // pointer at last level
      mem[36'h4002C] = 32'h0000_0F00;              // invalid, nonzero
      mem[36'h40030] = 32'h0000_0003;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !mem_rd_req && !mem_wr_req, "R1", 64'({busy, done, mem_rd_req, mem_wr_req}), 64'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!busy && nreads == 0 && nwrites == 0, "R1", 64'(nreads + nwrites), 64'd0);

      // leaf at each level, write-back behaviour (R4, R9)
      do_txn(32'h0112_3456, 2'd0, "R4", 0);
      do_txn(32'h0112_3456, 2'd0, "R9", 0);
      do_txn(32'h01AB_CDEF, 2'd1, "R9", 0);
      do_txn(32'h0112_3456, 2'd1, "R9", 0);
      mem_lat = 4;
      do_txn(32'h0215_2ABC, 2'd2, "R4", 0);
      do_txn(32'h0218_9345, 2'd1, "R4", 0);
      mem_lat = 1;
      do_txn(32'h0218_9FFF, 2'd0, "R4", 0);
      // faults at each level
      do_txn(32'h0218_B000, 2'd0, "R5", 0);
      do_txn(32'h0218_A000, 2'd0, "R6", 0);
      do_txn(32'h0218_C010, 2'd1, "R6", 0);
      mem_lat = 3;
      do_txn(32'h021C_0000, 2'd0, "R5", 0);
      do_txn(32'h0220_0000, 2'd2, "R6", 0);
      do_txn(32'h0300_0000, 2'd0, "R5", 0);
      do_txn(32'h0400_0000, 2'd0, "R6", 0);
      cfg_ctx_num = 8'd4;
      do_txn(32'h0112_3456, 2'd0, "R5", 0);
      cfg_ctx_num = 8'd5;
      do_txn(32'h0112_3456, 2'd0, "R6", 0);
      cfg_ctx_num = 8'd3;
      // request during a walk is ignored (R11)
      mem_lat = 4;
      do_txn(32'h0218_9ABC, 2'd0, "R11", 1);
      mem_lat = 2;
      // translation off (R7) and boot window (R8)
      cfg_enable = 1'b0;
      do_txn(32'hDEAD_BEEF, 2'd0, "R7", 0);
      do_txn(32'h1234_5678, 2'd1, "R7", 0);
      do_txn(32'hFFF8_1234, 2'd2, "R7", 0);
      cfg_boot = 1'b1;
      do_txn(32'hFFF8_1234, 2'd2, "R8", 0);
      do_txn(32'h0007_FFFC, 2'd2, "R8", 0);
      do_txn(32'hFFF8_1234, 2'd0, "R8", 0);
      cfg_boot = 1'b0;
      cfg_enable = 1'b1;
      do_txn(32'h0215_0000, 2'd0, "R4", 0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule